// File: doc/BRIEF.md
# Jump Resolution and Next-Slot Address Unit

This block resolves the control-flow class of a 64-bit register machine whose instructions occupy 8-byte slots. Each cycle that `in_valid` is high it takes the current slot address, the 4-bit jump operation code, the operand-select bit, two 64-bit register values, a signed 16-bit displacement, a signed 32-bit immediate and a flag saying the current instruction fills two slots. One cycle later it presents the address of the next slot to fetch.

Alongside the address it reports four things:
- whether a branch was taken;
- whether a subroutine call was requested, and the call destination;
- whether the program is ending;
- whether the operation code is undefined.

Conditional forms compare the destination value with either the sign-extended immediate or the source register. The compare may be an equality test, an unsigned order, a signed order or a bit test. Return handling and the helper-routine mechanism sit outside this block.

Top module: `bnpc_unit`

## Requirements
- R1: While `rst_n` is low and after its release until the first accepted operation, `out_valid`, `next_pc`, `taken`, `call_req`, `call_target`, `exit_flag` and `illegal` are all zero.
- R2: An operation accepted with `in_valid` high at a clock edge is reported at the next edge with `out_valid` high; a cycle without `in_valid` yields `out_valid`, `taken`, `call_req`, `exit_flag` and `illegal` all low on the following cycle.
- R3: Code 0 (always) is taken unconditionally, with `next_pc` = `pc_in` + 1 + sign-extended `offset`, regardless of the register values and of `wide_insn`.
- R4: The compare operand is `src_val` when `src_sel` is 1, and `imm` sign-extended to 64 bits when `src_sel` is 0.
- R5: Code 1 is taken when dst equals the operand, code 5 when they differ, and code 4 when dst AND operand is nonzero.
- R6: Codes 2, 3, 10 and 11 are taken when dst is, as unsigned numbers, greater than, greater or equal to, less than, or less or equal to the operand, respectively.
- R7: Codes 6, 7, 12 and 13 make the same four comparisons as R6, treating both values as two's-complement signed.
- R8: A taken conditional sets `taken` and `next_pc` = `pc_in` + 1 + sign-extended `offset`, modulo 2^PC_W, so negative displacements and wraparound are honoured.
- R9: A conditional that is not taken clears `taken` and gives `next_pc` = `pc_in` + 1, or `pc_in` + 2 when `wide_insn` is 1.
- R10: Code 8 (call) sets `call_req` and `taken`, and gives `call_target` = `next_pc` = `pc_in` + 1 + sign-extended `imm`; for every other code `call_req` is low and `call_target` is zero.
- R11: Code 9 (exit) sets `exit_flag`, clears `taken`, and holds `next_pc` at `pc_in`.
- R12: Codes 14 and 15 set `illegal`, clear `taken`, `call_req` and `exit_flag`, and hold `next_pc` at `pc_in`; at most one of `call_req`, `exit_flag` and `illegal` is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| pc_in | input | PC_W | Current slot address |
| op_code | input | 4 | Jump operation code |
| src_sel | input | 1 | 1 selects `src_val`, 0 selects the immediate |
| dst_val | input | DATA_W | Destination register value |
| src_val | input | DATA_W | Source register value |
| offset | input | OFF_W | Signed branch displacement in slots |
| imm | input | IMM_W | Signed immediate, also the call displacement |
| wide_insn | input | 1 | Current instruction occupies two slots |
| out_valid | output | 1 | Result of last cycle's operation is present |
| next_pc | output | PC_W | Next slot address |
| taken | output | 1 | Control flow leaves the sequential path |
| call_req | output | 1 | Subroutine call requested |
| call_target | output | PC_W | Call destination slot address |
| exit_flag | output | 1 | Program end requested |
| illegal | output | 1 | Undefined operation code |

## Verification
The hardest cases to reach are those where signed and unsigned orders disagree. These arise only when the two operands differ in their top bit. Once the immediate is sign-extended, that top bit comes from bit 31 of the immediate. The stimulus therefore pairs an all-ones destination with small positive and negative immediates and registers, and runs every order code over those pairs. Slot-address wraparound is reached by driving addresses next to zero and to all ones with negative and positive displacements.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  typedef enum logic [3:0] {
    OP_ALWAYS = 4'h0,
    OP_EQ     = 4'h1,
    OP_UGT    = 4'h2,
    OP_UGE    = 4'h3,
    OP_BITS   = 4'h4,
    OP_NE     = 4'h5,
    OP_SGT    = 4'h6,
    OP_SGE    = 4'h7,
    OP_CALL   = 4'h8,
    OP_EXIT   = 4'h9,
    OP_ULT    = 4'hA,
    OP_ULE    = 4'hB,
    OP_SLT    = 4'hC,
    OP_SLE    = 4'hD,
    OP_RSV_E  = 4'hE,
    OP_RSV_F  = 4'hF
  } jop_e;

  typedef enum logic [1:0] {
    CMP_ORD_LT = 2'd0,
    CMP_ORD_EQ = 2'd1,
    CMP_ORD_GT = 2'd2
  } cmp_ord_e;

endpackage

// File: rtl/bnpc_cond.sv
module bnpc_cond
  import bnpc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic [3:0]        op_code,
  input  logic              src_sel,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic              is_cond,
  output logic              hit
);

  logic signed [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0]        opnd;
  cmp_ord_e                 ord_u;
  cmp_ord_e                 ord_s;

  function automatic cmp_ord_e order_of(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b,
                                        input logic              signed_mode);
    logic [DATA_W-1:0] fa;
    logic [DATA_W-1:0] fb;
    // flipping the sign bit maps two's-complement order onto unsigned order
    fa = signed_mode ? (a ^ (DATA_W'(1) << (DATA_W-1))) : a;
    fb = signed_mode ? (b ^ (DATA_W'(1) << (DATA_W-1))) : b;
    if (fa == fb)     return CMP_ORD_EQ;
    else if (fa < fb) return CMP_ORD_LT;
    else              return CMP_ORD_GT;
  endfunction

  assign imm_ext = $signed(imm);
  assign opnd    = src_sel ? src_val : imm_ext;
  assign ord_u   = order_of(dst_val, opnd, 1'b0);
  assign ord_s   = order_of(dst_val, opnd, 1'b1);

  always_comb begin
    is_cond = 1'b1;
    hit     = 1'b0;
    unique case (jop_e'(op_code))
      OP_EQ:   hit = (ord_u == CMP_ORD_EQ);
      OP_NE:   hit = (ord_u != CMP_ORD_EQ);
      OP_BITS: hit = |(dst_val & opnd);
      OP_UGT:  hit = (ord_u == CMP_ORD_GT);
      OP_UGE:  hit = (ord_u != CMP_ORD_LT);
      OP_ULT:  hit = (ord_u == CMP_ORD_LT);
      OP_ULE:  hit = (ord_u != CMP_ORD_GT);
      OP_SGT:  hit = (ord_s == CMP_ORD_GT);
      OP_SGE:  hit = (ord_s != CMP_ORD_LT);
      OP_SLT:  hit = (ord_s == CMP_ORD_LT);
      OP_SLE:  hit = (ord_s != CMP_ORD_GT);
      default: is_cond = 1'b0;
    endcase
  end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int IMM_W = 32
) (
  input  logic [PC_W-1:0]  pc_in,
  input  logic [OFF_W-1:0] offset,
  input  logic [IMM_W-1:0] imm,
  input  logic             wide_insn,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  jump_pc,
  output logic [PC_W-1:0]  call_pc
);

  logic [PC_W-1:0]        pc_plus1;
  logic signed [PC_W-1:0] off_ext;
  logic signed [PC_W-1:0] imm_ext;

  assign off_ext  = $signed(offset);
  assign imm_ext  = $signed(imm);
  assign pc_plus1 = pc_in + PC_W'(1);
  assign seq_pc   = pc_plus1 + PC_W'(wide_insn);
  assign jump_pc  = pc_plus1 + off_ext;
  assign call_pc  = pc_plus1 + imm_ext;

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [3:0]        op_code,
  input  logic              src_sel,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [OFF_W-1:0]  offset,
  input  logic [IMM_W-1:0]  imm,
  input  logic              wide_insn,
  output logic              out_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              call_req,
  output logic [PC_W-1:0]   call_target,
  output logic              exit_flag,
  output logic              illegal
);

  logic            cond_sel;
  logic            cond_hit;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] jump_pc;
  logic [PC_W-1:0] call_pc;

  logic [PC_W-1:0] nx_pc;
  logic [PC_W-1:0] nx_call_pc;
  logic            nx_taken;
  logic            nx_call;
  logic            nx_exit;
  logic            nx_illegal;

  bnpc_cond #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cond (
    .op_code (op_code),
    .src_sel (src_sel),
    .dst_val (dst_val),
    .src_val (src_val),
    .imm     (imm),
    .is_cond (cond_sel),
    .hit     (cond_hit)
  );

  bnpc_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_tgt (
    .pc_in     (pc_in),
    .offset    (offset),
    .imm       (imm),
    .wide_insn (wide_insn),
    .seq_pc    (seq_pc),
    .jump_pc   (jump_pc),
    .call_pc   (call_pc)
  );

  always_comb begin
    nx_pc      = seq_pc;
    nx_call_pc = '0;
    nx_taken   = 1'b0;
    nx_call    = 1'b0;
    nx_exit    = 1'b0;
    nx_illegal = 1'b0;
    unique case (jop_e'(op_code))
      OP_ALWAYS: begin
        nx_taken = 1'b1;
        nx_pc    = jump_pc;
      end
      OP_CALL: begin
        nx_taken   = 1'b1;
        nx_call    = 1'b1;
        nx_call_pc = call_pc;
        nx_pc      = call_pc;
      end
      OP_EXIT: begin
        nx_exit = 1'b1;
        nx_pc   = pc_in;
      end
      OP_RSV_E, OP_RSV_F: begin
        nx_illegal = 1'b1;
        nx_pc      = pc_in;
      end
      default: begin
        nx_taken = cond_sel & cond_hit;
        nx_pc    = (cond_sel & cond_hit) ? jump_pc : seq_pc;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      next_pc     <= '0;
      taken       <= 1'b0;
      call_req    <= 1'b0;
      call_target <= '0;
      exit_flag   <= 1'b0;
      illegal     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid & nx_taken;
      call_req  <= in_valid & nx_call;
      exit_flag <= in_valid & nx_exit;
      illegal   <= in_valid & nx_illegal;
      if (in_valid) begin
        next_pc     <= nx_pc;
        call_target <= nx_call_pc;
      end
    end
  end

endmodule

// File: rtl/bnpc_checker.sv
module bnpc_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [PC_W-1:0] pc_in,
  input logic            out_valid,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic            call_req,
  input logic [PC_W-1:0] call_target,
  input logic            exit_flag,
  input logic            illegal,
  input logic            cond_sel,
  input logic            cond_hit
);

  assert_accept_reports_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !taken && !call_req && !exit_flag && !illegal));

  assert_hit_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel && cond_hit) |=> taken);

  assert_miss_not_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel && !cond_hit) |=> !taken);

  assert_call_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (taken && next_pc == call_target));

  assert_exit_holds_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exit_flag |-> (!taken && next_pc == $past(pc_in)));

  assert_illegal_holds_pc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!taken && next_pc == $past(pc_in)));

  assert_one_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({call_req, exit_flag, illegal}));

endmodule

bind bnpc_unit bnpc_checker #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .pc_in       (pc_in),
  .out_valid   (out_valid),
  .next_pc     (next_pc),
  .taken       (taken),
  .call_req    (call_req),
  .call_target (call_target),
  .exit_flag   (exit_flag),
  .illegal     (illegal),
  .cond_sel    (cond_sel),
  .cond_hit    (cond_hit)
);

// File: tb/sim_bnpc_unit.sv
module sim_bnpc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] pc_in = '0;
  logic [3:0]  op_code = '0;
  logic        src_sel = 1'b0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [15:0] offset = '0;
  logic [31:0] imm = '0;
  logic        wide_insn = 1'b0;
  logic        out_valid;
  logic [31:0] next_pc;
  logic        taken;
  logic        call_req;
  logic [31:0] call_target;
  logic        exit_flag;
  logic        illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct {
    string       tag;
    logic [31:0] npc;
    logic        tk;
    logic        cr;
    logic [31:0] ct;
    logic        ex;
    logic        il;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  bnpc_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in),
    .op_code(op_code), .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val),
    .offset(offset), .imm(imm), .wide_insn(wide_insn), .out_valid(out_valid),
    .next_pc(next_pc), .taken(taken), .call_req(call_req),
    .call_target(call_target), .exit_flag(exit_flag), .illegal(illegal)
  );

  // reference: the spec restated as a plain decision, signed compares via $signed
  function automatic exp_t model(string tag, logic [31:0] pc, logic [3:0] op,
                                 logic sel, logic [63:0] d, logic [63:0] s,
                                 logic [15:0] off, logic [31:0] im, logic w);
    exp_t e;
    logic [63:0] b;
    logic        t;
    b = sel ? s : {{32{im[31]}}, im};
    e.tag = tag; e.tk = 0; e.cr = 0; e.ct = '0; e.ex = 0; e.il = 0;
    t = 0;
    case (op)
      4'h1: t = (d == b);
      4'h5: t = (d != b);
      4'h4: t = ((d & b) != 0);
      4'h2: t = (d > b);
      4'h3: t = (d >= b);
      4'hA: t = (d < b);
      4'hB: t = (d <= b);
      4'h6: t = ($signed(d) > $signed(b));
      4'h7: t = ($signed(d) >= $signed(b));
      4'hC: t = ($signed(d) < $signed(b));
      4'hD: t = ($signed(d) <= $signed(b));
      default: t = 0;
    endcase
    if (op == 4'h0) begin
      e.tk = 1; e.npc = pc + 32'd1 + {{16{off[15]}}, off};
    end else if (op == 4'h8) begin
      e.tk = 1; e.cr = 1; e.ct = pc + 32'd1 + im; e.npc = e.ct;
    end else if (op == 4'h9) begin
      e.ex = 1; e.npc = pc;
    end else if (op >= 4'hE) begin
      e.il = 1; e.npc = pc;
    end else if (t) begin
      e.tk = 1; e.npc = pc + 32'd1 + {{16{off[15]}}, off};
    end else begin
      e.npc = pc + (w ? 32'd2 : 32'd1);
    end
    return e;
  endfunction

  task automatic drive(string tag, logic [31:0] pc, logic [3:0] op, logic sel,
                       logic [63:0] d, logic [63:0] s, logic [15:0] off,
                       logic [31:0] im, logic w);
    @(negedge clk);
    pc_in = pc; op_code = op; src_sel = sel; dst_val = d; src_val = s;
    offset = off; imm = im; wide_insn = w; in_valid = 1'b1;
    sb.push_back(model(tag, pc, op, sel, d, s, off, im, w));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops one expectation per reported result
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        exp_t e;
        n_checks++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R2: result with no pending operation, actual out_valid=1 expected 0");
        end else begin
          e = sb.pop_front();
          if (next_pc !== e.npc || taken !== e.tk || call_req !== e.cr ||
              call_target !== e.ct || exit_flag !== e.ex || illegal !== e.il) begin
            n_fail++;
            $display("FAIL %s: actual pc=%h tk=%b cr=%b ct=%h ex=%b il=%b expected pc=%h tk=%b cr=%b ct=%h ex=%b il=%b",
                     e.tag, next_pc, taken, call_req, call_target, exit_flag, illegal,
                     e.npc, e.tk, e.cr, e.ct, e.ex, e.il);
          end
        end
      end
    end
  end

  task automatic check_quiet(string tag);
    n_checks++;
    if (out_valid !== 0 || taken !== 0 || call_req !== 0 || exit_flag !== 0 || illegal !== 0) begin
      n_fail++;
      $display("FAIL %s: actual v=%b tk=%b cr=%b ex=%b il=%b expected all 0",
               tag, out_valid, taken, call_req, exit_flag, illegal);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 0 || next_pc !== 0 || taken !== 0 || call_req !== 0 ||
        call_target !== 0 || exit_flag !== 0 || illegal !== 0) begin
      n_fail++;
      $display("FAIL R1: actual v=%b pc=%h ct=%h expected all zero", out_valid, next_pc, call_target);
    end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 0 || next_pc !== 0 || call_target !== 0) begin
      n_fail++;
      $display("FAIL R1: actual v=%b pc=%h expected 0 after release", out_valid, next_pc);
    end

    // R3 unconditional
    drive("R3", 32'd100, 4'h0, 0, 64'd5, 64'd9, 16'd7, 32'd0, 1);
    drive("R3", 32'd100, 4'h0, 1, 64'd0, ONES, 16'hFFF0, 32'd3, 0);
    // R5 equality, inequality, bit test; R4 operand select
    drive("R5", 32'd10, 4'h1, 1, 64'd42, 64'd42, 16'd4, 32'd0, 0);
    drive("R5", 32'd10, 4'h1, 1, 64'd42, 64'd43, 16'd4, 32'd0, 0);
    drive("R4", 32'd10, 4'h1, 0, ONES, 64'd0, 16'd4, 32'hFFFF_FFFF, 0);
    drive("R4", 32'd10, 4'h1, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 16'd4, 32'hFFFF_FFFF, 0);
    drive("R5", 32'd10, 4'h5, 1, 64'd1, 64'd2, 16'd3, 32'd0, 0);
    drive("R5", 32'd10, 4'h5, 0, 64'd7, 64'd2, 16'd3, 32'd7, 0);
    drive("R5", 32'd20, 4'h4, 0, 64'h10, 64'd0, 16'd1, 32'h30, 0);
    drive("R5", 32'd20, 4'h4, 1, 64'h10, 64'h0F, 16'd1, 32'h10, 0);
    // R6 unsigned vs R7 signed with top-bit disagreement
    for (int k = 0; k < 4; k++) begin
      logic [3:0] uop;
      logic [3:0] sop;
      uop = (k == 0) ? 4'h2 : (k == 1) ? 4'h3 : (k == 2) ? 4'hA : 4'hB;
      sop = (k == 0) ? 4'h6 : (k == 1) ? 4'h7 : (k == 2) ? 4'hC : 4'hD;
      drive("R6", 32'd50, uop, 0, ONES, 64'd0, 16'd8, 32'd1, 0);
      drive("R7", 32'd50, sop, 0, ONES, 64'd0, 16'd8, 32'd1, 0);
      drive("R6", 32'd50, uop, 1, 64'd3, 64'd3, 16'd8, 32'd0, 1);
      drive("R7", 32'd50, sop, 1, 64'd3, 64'd3, 16'd8, 32'd0, 1);
      drive("R6", 32'd50, uop, 0, 64'd5, 64'd0, 16'd8, 32'hFFFF_FFFE, 0);
      drive("R7", 32'd50, sop, 0, 64'd5, 64'd0, 16'd8, 32'hFFFF_FFFE, 0);
      drive("R7", 32'd50, sop, 1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 16'd8, 32'd0, 0);
    end
    // R8 negative displacement and wraparound
    drive("R8", 32'd0, 4'h1, 1, 64'd1, 64'd1, 16'hFFFE, 32'd0, 0);
    drive("R8", 32'hFFFF_FFFE, 4'h0, 0, 64'd0, 64'd0, 16'd5, 32'd0, 0);
    drive("R8", 32'd1000, 4'h6, 0, 64'd9, 64'd0, 16'h8000, 32'd2, 0);
    // R9 not taken, single and wide
    drive("R9", 32'd300, 4'h1, 1, 64'd1, 64'd2, 16'd40, 32'd0, 0);
    drive("R9", 32'd300, 4'h1, 1, 64'd1, 64'd2, 16'd40, 32'd0, 1);
    drive("R9", 32'hFFFF_FFFF, 4'h5, 1, 64'd4, 64'd4, 16'd40, 32'd0, 1);
    // R10 call
    drive("R10", 32'd500, 4'h8, 0, 64'd0, 64'd0, 16'd0, 32'd99, 0);
    drive("R10", 32'd500, 4'h8, 0, 64'd0, 64'd0, 16'd0, 32'hFFFF_FF00, 0);
    // R11 exit, R12 reserved codes
    drive("R11", 32'd777, 4'h9, 0, 64'd0, 64'd0, 16'd0, 32'd0, 1);
    drive("R12", 32'd888, 4'hE, 1, 64'd1, 64'd1, 16'd3, 32'd5, 0);
    drive("R12", 32'd889, 4'hF, 0, 64'd1, 64'd1, 16'd3, 32'd5, 1);
    drive("R10", 32'd600, 4'h1, 1, 64'd1, 64'd1, 16'd2, 32'd77, 0);

    idle(1);
    @(negedge clk);
    check_quiet("R2");
    idle(2);
    check_quiet("R2");
    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R2: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end

endmodule